// File: doc/BRIEF.md
# Host Memory Window

This block lets a host reach two regions of on-chip memory through two small registers: a 16-bit window pointer and a 32-bit data register. The host sees both as byte-wide offsets. The pointer holds three things: the access type in its two lowest bits, a word offset in the middle bits, and a region select in its top bit. When the host touches a byte lane of the data register, the block may turn that touch into a request on the internal memory port. Whether it does depends on the access type. The host gets its answer without any help from the embedded processor.

The processor sets up each region with three values: a word-aligned base address, a read limit and a write limit, all held on configuration inputs. An access whose starting byte offset is not below the matching limit never reaches memory. A blocked read returns all-ones, and any blocked access raises a sticky error flag for the processor. With these limits a region can be made read-only, write-only or read/write from the host side. In the word auto-increment type, the word offset steps forward after each word transfer, so a host can stream a block of memory with repeated data-register accesses.

Top module: `host_mem_window`

## Requirements
- R1: After a synchronous active-low reset, the pointer is zero, the data register is zero, `err_flag` is low and `mem_req` is low.
- R2: Offset 0 reads and writes pointer bits [7:0] and offset 1 reads and writes bits [15:8]. Each host request is answered by exactly one single-cycle `host_ack`.
- R3: Access type 00 (byte). Every read or write of data lane L (offsets 4+L) is one memory access with byte enable 1<<L. The memory address is base + word offset × 4, and the region offset checked is word offset × 4 + L.
- R4: Access type 01 (halfword). A write to lane 1 or 3 commits that lane and the lane below it, with byte enable 0011 or 1100. A read of lane 0 or 2 fetches the same pair. Writes to even lanes and reads of odd lanes cause no memory access.
- R5: Access types 10 and 11 (word). Writes to lanes 0 to 2 only fill the data register. A write to lane 3 commits all four bytes with byte enable 1111. A read of lane 0 fetches the whole word. Reads of lanes 1 to 3 return the held bytes without a memory access.
- R6: With type 11, the word offset (pointer bits [14:2]) increases by one after each lane-3 write and each lane-0 read. The type and region bits are unchanged. With type 10 the pointer never changes.
- R7: Pointer bit 15 selects region 1's base and limits when set and region 0's when clear.
- R8: A read whose starting offset is at or above the region's read limit makes no memory access, returns 0xFF in each enabled lane, and sets `err_flag`.
- R9: A write whose starting offset is at or above the region's write limit makes no memory access, leaves memory unchanged, and sets `err_flag`.
- R10: `err_flag` stays set until `err_clr` is pulsed. A new block event in the same cycle as the clear takes priority, so the flag stays set.
- R11: `mem_req` is held with stable address, byte enable, direction and write data until `mem_ack`. A memory request only follows a host request.
- R12: Offsets 2 and 3 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Single-cycle host access strobe, accepted when idle |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_off | input | 3 | Register offset: 0/1 pointer bytes, 4..7 data lanes |
| host_wdata | input | 8 | Host write byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Read byte, valid with host_ack |
| cfg_base0 | input | MAW-2 | Region 0 base, word address |
| cfg_base1 | input | MAW-2 | Region 1 base, word address |
| cfg_rlim0 | input | AW | Region 0 read limit in bytes |
| cfg_rlim1 | input | AW | Region 1 read limit in bytes |
| cfg_wlim0 | input | AW | Region 0 write limit in bytes |
| cfg_wlim1 | input | AW | Region 1 write limit in bytes |
| err_clr | input | 1 | Clears the error flag |
| err_flag | output | 1 | Sticky blocked-access flag |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write when set |
| mem_addr | output | MAW | Word-aligned byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completion |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The bench first targets the lanes that must not reach memory: the partial-word writes and the held-byte reads. A design that commits on every lane would show extra memory accesses, or would write words with bytes still missing. It then checks the limits exactly at the boundary: the last allowed byte and the first blocked one. An off-by-one compare would let one word through or block one word too many. It also covers a write-only region, where a read must return all-ones and raise the flag. Finally, it streams two words in both directions with auto-increment, and checks that plain word mode leaves the pointer alone. Misplaced increments would shift or duplicate words in the transferred block.

// File: rtl/hmw_pkg.sv
// Package: shared types and constants for the host memory window.
// Assumes a 32-bit internal memory word split into four byte lanes.
package hmw_pkg;
    localparam int LANES = 4;

    typedef enum logic [1:0] {
        ACC_BYTE     = 2'b00,
        ACC_HALF     = 2'b01,
        ACC_WORD     = 2'b10,
        ACC_WORD_INC = 2'b11
    } acc_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_MEM  = 2'b01,
        ST_ACK  = 2'b10
    } st_t;

    localparam logic [2:0] OFF_PTR_LO = 3'd0;
    localparam logic [2:0] OFF_PTR_HI = 3'd1;
endpackage

// File: rtl/hmw_access_decode.sv
// Access decoder: from the access type, the touched lane and the direction,
// decides whether a memory operation is due, which byte enables it uses,
// the first lane of the access and whether the pointer advances.
// Purely combinational; assumes one host access per evaluation.
module hmw_access_decode
    import hmw_pkg::*;
(
    input  acc_t       acc,
    input  logic [1:0] lane,
    input  logic       is_write,
    output logic       mem_op,
    output logic [3:0] be,
    output logic [1:0] start_lane,
    output logic       bump
);
    // Map access type and lane onto memory action
    always_comb begin
        mem_op     = 1'b0;
        be         = 4'b0000;
        start_lane = 2'b00;
        bump       = 1'b0;
        unique case (acc)
            ACC_BYTE: begin
                mem_op     = 1'b1;
                be         = 4'b0001 << lane;
                start_lane = lane;
            end
            ACC_HALF: begin
                be         = lane[1] ? 4'b1100 : 4'b0011;
                start_lane = {lane[1], 1'b0};
                mem_op     = is_write ? lane[0] : ~lane[0];
            end
            default: begin
                be         = 4'b1111;
                start_lane = 2'b00;
                mem_op     = is_write ? (lane == 2'd3) : (lane == 2'd0);
                bump       = (acc == ACC_WORD_INC) &&
                             (is_write ? (lane == 2'd3) : (lane == 2'd0));
            end
        endcase
    end
endmodule

// File: rtl/hmw_region_check.sv
// Region check: picks the selected region's base and limit, tests the
// starting byte offset against the limit for the access direction and
// forms the memory word address. Purely combinational.
// Assumes the memory word address is at least as wide as the word offset.
module hmw_region_check #(
    parameter int AW  = 16,
    parameter int MAW = 20
) (
    input  logic             region,
    input  logic [AW-4:0]    woff,
    input  logic [1:0]       start_lane,
    input  logic             is_write,
    input  logic [MAW-3:0]   base0,
    input  logic [MAW-3:0]   base1,
    input  logic [AW-1:0]    rlim0,
    input  logic [AW-1:0]    rlim1,
    input  logic [AW-1:0]    wlim0,
    input  logic [AW-1:0]    wlim1,
    output logic             allowed,
    output logic [MAW-3:0]   word_addr
);
    localparam int WOFF_W = AW - 3;
    localparam int PAD_W  = MAW - 2 - WOFF_W;

    logic [AW-1:0]  start_off;
    logic [AW-1:0]  lim_sel;
    logic [MAW-3:0] base_sel;

    // Select region parameters and test the limit
    always_comb begin
        start_off = {1'b0, woff, start_lane};
        base_sel  = region ? base1 : base0;
        if (is_write) lim_sel = region ? wlim1 : wlim0;
        else          lim_sel = region ? rlim1 : rlim0;
        allowed   = start_off < lim_sel;
        word_addr = base_sel + {{PAD_W{1'b0}}, woff};
    end
endmodule

// File: rtl/hmw_data_lanes.sv
// Data register: four byte lanes loaded either by host byte writes or by
// a masked fill from memory (or all-ones on a blocked read).
// Assumes fill and host write never target the same cycle.
module hmw_data_lanes
    import hmw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_lane,
    input  logic [7:0]  wr_byte,
    input  logic        fill_en,
    input  logic [3:0]  fill_be,
    input  logic [31:0] fill_word,
    output logic [31:0] data_q
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Update one byte lane from fill or host write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[8*g +: 8] <= 8'h00;
            end else if (fill_en && fill_be[g]) begin
                data_q[8*g +: 8] <= fill_word[8*g +: 8];
            end else if (wr_en && (wr_lane == 2'(g))) begin
                data_q[8*g +: 8] <= wr_byte;
            end
        end
    end
endmodule

// File: rtl/host_mem_window.sv
// Host memory window top: pointer register, data register, access control
// state machine and the memory request port. The host issues one-cycle
// strobes and waits for host_ack before the next; strobes arriving while
// busy are dropped. Pointer: [1:0] access type, [AW-2:2] word offset,
// [AW-1] region select. Assumes 9 <= AW <= 16.
module host_mem_window
    import hmw_pkg::*;
#(
    parameter int AW  = 16,
    parameter int MAW = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_we,
    input  logic [2:0]       host_off,
    input  logic [7:0]       host_wdata,
    output logic             host_ack,
    output logic [7:0]       host_rdata,
    input  logic [MAW-3:0]   cfg_base0,
    input  logic [MAW-3:0]   cfg_base1,
    input  logic [AW-1:0]    cfg_rlim0,
    input  logic [AW-1:0]    cfg_rlim1,
    input  logic [AW-1:0]    cfg_wlim0,
    input  logic [AW-1:0]    cfg_wlim1,
    input  logic             err_clr,
    output logic             err_flag,
    output logic             mem_req,
    output logic             mem_we,
    output logic [MAW-1:0]   mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata
);
    localparam int WOFF_W = AW - 3;
    localparam int HI_W   = AW - 8;

    st_t             state_q;
    logic [AW-1:0]   ptr_q;
    logic [7:0]      reg_rd_q;
    logic            sel_data_q;
    logic [1:0]      lane_q;
    logic            err_q;
    logic            mreq_q;
    logic            mwe_q;
    logic [MAW-3:0]  maddr_q;
    logic [3:0]      mbe_q;

    acc_t            acc_cur;
    logic [WOFF_W-1:0] woff_cur;
    logic            region_cur;
    logic            accept;
    logic            data_acc;
    logic            mem_op;
    logic [3:0]      dec_be;
    logic [1:0]      dec_start;
    logic            dec_bump;
    logic            allowed;
    logic [MAW-3:0]  word_addr;
    logic            go_mem;
    logic            blocked;
    logic            fill_en;
    logic [3:0]      fill_be;
    logic [31:0]     fill_word;
    logic [31:0]     data_q;

    // Split the pointer and qualify the incoming strobe
    always_comb begin
        acc_cur    = acc_t'(ptr_q[1:0]);
        woff_cur   = ptr_q[AW-2:2];
        region_cur = ptr_q[AW-1];
        accept     = (state_q == ST_IDLE) && host_req;
        data_acc   = accept && host_off[2];
        go_mem     = data_acc && mem_op && allowed;
        blocked    = data_acc && mem_op && !allowed;
    end

    hmw_access_decode u_dec (
        .acc        (acc_cur),
        .lane       (host_off[1:0]),
        .is_write   (host_we),
        .mem_op     (mem_op),
        .be         (dec_be),
        .start_lane (dec_start),
        .bump       (dec_bump)
    );

    hmw_region_check #(.AW(AW), .MAW(MAW)) u_chk (
        .region     (region_cur),
        .woff       (woff_cur),
        .start_lane (dec_start),
        .is_write   (host_we),
        .base0      (cfg_base0),
        .base1      (cfg_base1),
        .rlim0      (cfg_rlim0),
        .rlim1      (cfg_rlim1),
        .wlim0      (cfg_wlim0),
        .wlim1      (cfg_wlim1),
        .allowed    (allowed),
        .word_addr  (word_addr)
    );

    // Choose the data register fill source: memory return or blocked read
    always_comb begin
        if (state_q == ST_MEM) begin
            fill_en   = mem_ack && !mwe_q;
            fill_be   = mbe_q;
            fill_word = mem_rdata;
        end else begin
            fill_en   = blocked && !host_we;
            fill_be   = dec_be;
            fill_word = '1;
        end
    end

    hmw_data_lanes u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_acc && host_we),
        .wr_lane   (host_off[1:0]),
        .wr_byte   (host_wdata),
        .fill_en   (fill_en),
        .fill_be   (fill_be),
        .fill_word (fill_word),
        .data_q    (data_q)
    );

    // Sequence host accesses through idle, memory wait and acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) state_q <= go_mem ? ST_MEM : ST_ACK;
                ST_MEM:  if (mem_ack) state_q <= ST_ACK;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Maintain the pointer: host byte writes and auto-increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (accept && !host_off[2] && host_we) begin
            if (host_off == OFF_PTR_LO) ptr_q[7:0]    <= host_wdata;
            if (host_off == OFF_PTR_HI) ptr_q[AW-1:8] <= host_wdata[HI_W-1:0];
        end else if (data_acc && dec_bump) begin
            ptr_q[AW-2:2] <= woff_cur + WOFF_W'(1);
        end
    end

    // Capture what the acknowledge cycle must return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rd_q   <= 8'h00;
            sel_data_q <= 1'b0;
            lane_q     <= 2'b00;
        end else if (accept) begin
            sel_data_q <= host_off[2];
            lane_q     <= host_off[1:0];
            if (host_off == OFF_PTR_LO)      reg_rd_q <= ptr_q[7:0];
            else if (host_off == OFF_PTR_HI) reg_rd_q <= 8'(ptr_q[AW-1:8]);
            else                             reg_rd_q <= 8'h00;
        end
    end

    // Issue and hold memory requests until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mreq_q  <= 1'b0;
            mwe_q   <= 1'b0;
            maddr_q <= '0;
            mbe_q   <= 4'b0000;
        end else if (go_mem) begin
            mreq_q  <= 1'b1;
            mwe_q   <= host_we;
            maddr_q <= word_addr;
            mbe_q   <= dec_be;
        end else if (state_q == ST_MEM && mem_ack) begin
            mreq_q  <= 1'b0;
        end
    end

    // Sticky error flag; a new block event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (blocked) err_q <= 1'b1;
        else if (err_clr) err_q <= 1'b0;
    end

    // Drive outputs
    always_comb begin
        host_ack   = (state_q == ST_ACK);
        host_rdata = 8'h00;
        if (host_ack) host_rdata = sel_data_q ? data_q[{lane_q, 3'b000} +: 8] : reg_rd_q;
        err_flag   = err_q;
        mem_req    = mreq_q;
        mem_we     = mwe_q;
        mem_addr   = {maddr_q, 2'b00};
        mem_be     = mbe_q;
        mem_wdata  = data_q;
    end
endmodule

// File: rtl/host_mem_window_sva.sv
// Protocol checker for the host memory window, bound to the top module.
// Observes ports only; assumes synchronous active-low reset.
module host_mem_window_sva #(
    parameter int MAW = 20
) (
    input logic           clk,
    input logic           rst_n,
    input logic           host_req,
    input logic           host_ack,
    input logic           err_clr,
    input logic           err_flag,
    input logic           mem_req,
    input logic           mem_we,
    input logic [MAW-1:0] mem_addr,
    input logic [3:0]     mem_be,
    input logic [31:0]    mem_wdata,
    input logic           mem_ack
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                                   && $stable(mem_we) && $stable(mem_wdata))); // R11

    AST_REQ_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(host_req)); // R11

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack); // R2

    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || mem_be == 4'b0011 ||
                     mem_be == 4'b1100 || mem_be == 4'b1111)); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag); // R10
endmodule

bind host_mem_window host_mem_window_sva #(.MAW(MAW)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_req  (host_req),
    .host_ack  (host_ack),
    .err_clr   (err_clr),
    .err_flag  (err_flag),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/host_mem_window_tb_top.sv
module host_mem_window_tb_top;
    localparam int AW  = 16;
    localparam int MAW = 20;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             host_req = 1'b0, host_we = 1'b0;
    logic [2:0]       host_off = '0;
    logic [7:0]       host_wdata = '0;
    logic             host_ack;
    logic [7:0]       host_rdata;
    logic             err_clr = 1'b0, err_flag;
    logic             mem_req, mem_we;
    logic [MAW-1:0]   mem_addr;
    logic [3:0]       mem_be;
    logic [31:0]      mem_wdata;
    logic             mem_ack;
    logic [31:0]      mem_rdata;

    host_mem_window #(.AW(AW), .MAW(MAW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_off(host_off),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .cfg_base0(18'h00040), .cfg_base1(18'h00080),
        .cfg_rlim0(16'h0040), .cfg_rlim1(16'h0000),
        .cfg_wlim0(16'h0040), .cfg_wlim1(16'h0020),
        .err_clr(err_clr), .err_flag(err_flag),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory model with fixed latency; counts accesses and checks request stability
    logic [31:0] mem [256];
    int          acc_cnt = 0, stab_err = 0, lcnt = 0;
    logic        pend = 1'b0;
    logic [MAW-1:0] s_addr;
    logic [3:0]  s_be, last_be;
    logic        s_we;
    logic [31:0] s_wd;
    initial mem_ack = 1'b0;
    initial mem_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            pend    <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (!pend) begin
            if (mem_req) begin
                pend <= 1'b1; lcnt <= 1;
                s_addr <= mem_addr; s_be <= mem_be; s_we <= mem_we; s_wd <= mem_wdata;
            end
        end else begin
            if (!mem_req || mem_addr !== s_addr || mem_be !== s_be ||
                mem_we !== s_we || mem_wdata !== s_wd) stab_err <= stab_err + 1;
            if (lcnt == LAT) begin
                pend    <= 1'b0;
                mem_ack <= 1'b1;
                acc_cnt <= acc_cnt + 1;
                last_be <= s_be;
                if (s_we) begin
                    for (int b = 0; b < 4; b++)
                        if (s_be[b]) mem[s_addr[9:2]][8*b +: 8] <= s_wd[8*b +: 8];
                end else begin
                    mem_rdata <= mem[s_addr[9:2]];
                end
            end else begin
                lcnt <= lcnt + 1;
            end
        end
    end

    int n_chk = 0, n_fail = 0;

    function automatic logic [31:0] init_word(int i);
        logic [7:0] v = 8'(i);
        return {v ^ 8'h44, v ^ 8'h33, v ^ 8'h22, v ^ 8'h11};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_xfer(input logic we, input logic [2:0] off,
                             input logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_off = off; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        while (!host_ack) @(negedge clk);
        rd = host_rdata;
        @(negedge clk);
    endtask

    task automatic hwr(input logic [2:0] off, input logic [7:0] wd);
        logic [7:0] d;
        host_xfer(1'b1, off, wd, d);
    endtask

    task automatic hrd(input logic [2:0] off, output logic [7:0] rd);
        host_xfer(1'b0, off, 8'h00, rd);
    endtask

    task automatic set_ptr(input logic [15:0] p);
        hwr(3'd0, p[7:0]);
        hwr(3'd1, p[15:8]);
    endtask

    task automatic pulse_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        chk("R1 err_flag", 32'(err_flag), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        hrd(3'd0, r); chk("R1 ptr lo", 32'(r), 0);
        hrd(3'd1, r); chk("R1 ptr hi", 32'(r), 0);
    endtask

    task automatic t_ptr_regs();
        logic [7:0] r;
        set_ptr(16'h1234);
        hrd(3'd0, r); chk("R2 ptr lo", 32'(r), 32'h34);
        hrd(3'd1, r); chk("R2 ptr hi", 32'(r), 32'h12);
        hwr(3'd2, 8'hAA); hwr(3'd3, 8'h55);
        hrd(3'd2, r); chk("R12 off2", 32'(r), 0);
        hrd(3'd3, r); chk("R12 off3", 32'(r), 0);
        hrd(3'd0, r); chk("R12 ptr untouched", 32'(r), 32'h34);
    endtask

    task automatic t_byte();
        logic [7:0] r; int c0;
        set_ptr(16'h0008);
        c0 = acc_cnt;
        hrd(3'd5, r);
        chk("R3 byte read", 32'(r), 32'(init_word(66)[15:8]));
        chk("R3 byte read be", 32'(last_be), 32'h2);
        hwr(3'd7, 8'h5A);
        chk("R3 byte write mem", mem[66], {8'h5A, init_word(66)[23:0]});
        chk("R3 byte write be", 32'(last_be), 32'h8);
        chk("R3 access count", acc_cnt - c0, 2);
    endtask

    task automatic t_half();
        logic [7:0] r; int c0;
        set_ptr(16'h0009);
        c0 = acc_cnt;
        hwr(3'd4, 8'hC3);
        chk("R4 even-lane write no access", acc_cnt - c0, 0);
        hwr(3'd5, 8'h3C);
        chk("R4 half commit", mem[66][15:0], 32'h3CC3);
        chk("R4 half be", 32'(last_be), 32'h3);
        hrd(3'd6, r);
        chk("R4 half fetch byte2", 32'(r), 32'(init_word(66)[23:16]));
        chk("R4 half fetch be", 32'(last_be), 32'hC);
        hrd(3'd7, r);
        chk("R4 odd-lane read held", 32'(r), 32'h5A);
        chk("R4 access count", acc_cnt - c0, 2);
    endtask

    task automatic t_word();
        logic [7:0] r; int c0;
        set_ptr(16'h000E);
        c0 = acc_cnt;
        hwr(3'd4, 8'h01); hwr(3'd5, 8'h02); hwr(3'd6, 8'h03);
        chk("R5 partial write no access", acc_cnt - c0, 0);
        hwr(3'd7, 8'h04);
        chk("R5 word commit", mem[67], 32'h04030201);
        chk("R5 word be", 32'(last_be), 32'hF);
        mem[67] = 32'hDEADBEEF;
        hrd(3'd4, r); chk("R5 fetch lane0", 32'(r), 32'hEF);
        hrd(3'd5, r); chk("R5 held lane1", 32'(r), 32'hBE);
        hrd(3'd7, r); chk("R5 held lane3", 32'(r), 32'hDE);
        chk("R5 access count", acc_cnt - c0, 2);
        hrd(3'd0, r); chk("R6 no bump in type 10", 32'(r), 32'h0E);
    endtask

    task automatic t_autoinc();
        logic [7:0] r;
        set_ptr(16'h0013);
        for (int w = 0; w < 2; w++)
            for (int b = 0; b < 4; b++) hwr(3'(4 + b), 8'(16 * w + b + 8'h70));
        chk("R6 stream word0", mem[68], 32'h73727170);
        chk("R6 stream word1", mem[69], 32'h83828180);
        hrd(3'd0, r); chk("R6 pointer advanced", 32'(r), 32'h1B);
        hrd(3'd1, r); chk("R6 region kept", 32'(r), 0);
        set_ptr(16'h0013);
        for (int w = 0; w < 2; w++)
            for (int b = 0; b < 4; b++) begin
                hrd(3'(4 + b), r);
                chk("R6 stream read", 32'(r), 32'(8'(16 * w + b + 8'h70)));
            end
    endtask

    task automatic t_region1();
        logic [7:0] r; int c0;
        set_ptr(16'h8006);
        for (int b = 0; b < 4; b++) hwr(3'(4 + b), 8'(8'hB0 + b));
        chk("R7 region1 write", mem[129], 32'hB3B2B1B0);
        chk("R7 region0 untouched", mem[65], init_word(65));
        chk("R7 no error", 32'(err_flag), 0);
        c0 = acc_cnt;
        hrd(3'd4, r);
        chk("R8 write-only read ones", 32'(r), 32'hFF);
        hrd(3'd6, r);
        chk("R8 filled lane", 32'(r), 32'hFF);
        chk("R8 no access", acc_cnt - c0, 0);
        chk("R8 err set", 32'(err_flag), 1);
        repeat (3) @(negedge clk);
        chk("R10 err sticky", 32'(err_flag), 1);
        pulse_clr();
        chk("R10 err cleared", 32'(err_flag), 0);
    endtask

    task automatic t_read_limit();
        logic [7:0] r; int c0;
        set_ptr(16'h003C);
        hrd(3'd7, r);
        chk("R8 last byte allowed", 32'(r), 32'(init_word(79)[31:24]));
        chk("R8 no error at edge", 32'(err_flag), 0);
        set_ptr(16'h0040);
        c0 = acc_cnt;
        hrd(3'd4, r);
        chk("R8 first blocked byte", 32'(r), 32'hFF);
        chk("R8 blocked no access", acc_cnt - c0, 0);
        chk("R8 err at limit", 32'(err_flag), 1);
        pulse_clr();
    endtask

    task automatic t_write_limit();
        int c0;
        set_ptr(16'h8020);
        c0 = acc_cnt;
        for (int b = 0; b < 4; b++) hwr(3'(4 + b), 8'hEE);
        chk("R9 blocked no access", acc_cnt - c0, 0);
        chk("R9 memory unchanged", mem[136], init_word(136));
        chk("R9 err set", 32'(err_flag), 1);
        pulse_clr();
        set_ptr(16'h801E);
        for (int b = 0; b < 4; b++) hwr(3'(4 + b), 8'(8'hC0 + b));
        chk("R9 below limit written", mem[135], 32'hC3C2C1C0);
        chk("R9 no error below limit", 32'(err_flag), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = init_word(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ptr_regs();
        t_byte();
        t_half();
        t_word();
        t_autoinc();
        t_region1();
        t_read_limit();
        t_write_limit();
        chk("R11 request stable until ack", stab_err, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule